// File: doc/BRIEF.md
# Transmit Squelch With Post-Transmission Blanking

This block decides when a digitized transmit signal may drive the line. The analog front end delivers a single bit per fast-clock sample that is high while the transmit input is beyond the squelch threshold. The block applies three tests to that bit. A width filter rejects high runs that are too short to be real data. A no-pulse timer ends a transmission when no accepted pulse has arrived for about two bit periods. A blanking timer then stops trailing dribble pulses from starting a new transmission too early.

While a transmission is active, the sampled input is passed to the line output after a short fixed delay, with no inversion. The delay is chosen so that the start of the first accepted pulse is not cut off. An external disable from the jabber logic can force the line enable and the data output low at any time. It does not change the squelch state. A one-cycle end-of-transmission event goes to the heartbeat logic.

Timings are counted in clock cycles. At the intended 200 MHz clock, the defaults give a 20 ns minimum pulse (4 cycles), a 160 ns no-pulse timeout (32 cycles) and a 200 ns blanking window (40 cycles).

Top module: `tx_squelch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `tx_valid`, `tx_enable`, `tx_out` and `end_tx` are all 0.
- R2: A run of high samples on `tx_lvl` shorter than `MIN_PW` consecutive samples never starts a transmission.
- R3: If `tx_lvl` is sampled high for the `MIN_PW`-th consecutive time at edge n, while the block is idle and not blanking, `tx_valid` is 1 from the cycle after edge n. One run of high samples qualifies only once, however long it lasts.
- R4: During a transmission, every qualifying run restarts the no-pulse timer. `tx_valid` falls at the edge `IDLE_TO` cycles after the edge of the last qualifying sample.
- R5: `end_tx` is high for exactly one cycle, and that cycle is the first cycle in which `tx_valid` is 0 after a transmission.
- R6: After a transmission ends at edge e, a run whose qualifying sample falls at an edge in the range e+1 to e+`BLANK_LEN` is ignored. A qualifying sample at edge e+`BLANK_LEN`+1 or later starts a new transmission.
- R7: During a transmission with the disable low, `tx_out` after edge n equals `tx_lvl` as sampled at edge n-`MIN_PW`+1, not inverted. Outside a transmission `tx_out` is 0.
- R8: `tx_enable` after edge n equals the transmission state after that edge ANDed with the inverse of `tx_disable` sampled at that edge. A high `tx_disable` also forces `tx_out` to 0. `tx_disable` has no effect on `tx_valid`, `end_tx` or the timers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_lvl | input | 1 | Thresholded transmit input, 1 = beyond squelch threshold |
| tx_disable | input | 1 | Forced shutoff from the jabber logic |
| tx_enable | output | 1 | Line driver enable |
| tx_out | output | 1 | Gated, delayed transmit data |
| tx_valid | output | 1 | Squelch reports an active transmission |
| end_tx | output | 1 | One-cycle pulse when a transmission ends |

## Verification
The hardest case to reach is a pulse whose qualifying sample falls exactly on the last edge of the blanking window, or exactly one edge after it. Hitting it needs a transmission that has just timed out, followed by a gap tuned to the cycle. The stimulus sends a single qualifying pulse, waits the timeout plus a swept offset of 0 to 60 cycles, and then sends a second pulse. Every alignment around the window edge is covered this way. A width-by-gap sweep moves inter-pulse gaps across the timeout boundary, and a long pseudo-random pattern toggles the disable in the middle of transmissions.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ACTIVE = 2'd1,
    SQ_BLANK  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/tsq_width_filter.sv
// Counts consecutive high samples; flags the MIN_PW-th one, once per run.
module tsq_width_filter #(
  parameter int MIN_PW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic qual
);
  localparam int CW = $clog2(MIN_PW + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(MIN_PW);
  localparam logic [CW-1:0] CNT_HIT = CW'(MIN_PW - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (!lvl) begin
      run_cnt <= '0;
    end else if (run_cnt != CNT_SAT) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign qual = lvl && (run_cnt == CNT_HIT);
endmodule

// File: rtl/tsq_delay_line.sv
// Fixed-depth shift register aligning data with the qualification point.
module tsq_delay_line #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_chain
      logic [DEPTH-1:0] stage;
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= 1'b0;
        else     stage[0] <= din;
      end
      for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= 1'b0;
          else     stage[i] <= stage[i-1];
        end
      end
      assign dout = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/tsq_ctrl.sv
// Idle / active / blanking sequencer with no-pulse and blanking timers.
module tsq_ctrl
  import tsq_pkg::*;
#(
  parameter int IDLE_TO   = 32,
  parameter int BLANK_LEN = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic qual,
  output logic act_nxt,
  output logic act_q,
  output logic end_q
);
  localparam int GW = $clog2(IDLE_TO);
  localparam int BW = (BLANK_LEN > 1) ? $clog2(BLANK_LEN) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(IDLE_TO - 1);
  localparam logic [BW-1:0] BLK_LAST = BW'(BLANK_LEN - 1);

  sq_state_e st, st_n;
  logic [GW-1:0] gap, gap_n;
  logic [BW-1:0] blk, blk_n;
  logic end_n;

  always_comb begin
    st_n  = st;
    gap_n = gap;
    blk_n = blk;
    end_n = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        if (qual) begin
          st_n  = SQ_ACTIVE;
          gap_n = '0;
        end
      end
      SQ_ACTIVE: begin
        if (qual) begin
          gap_n = '0;
        end else if (gap == GAP_LAST) begin
          st_n  = SQ_BLANK;
          blk_n = '0;
          end_n = 1'b1;
        end else begin
          gap_n = gap + 1'b1;
        end
      end
      SQ_BLANK: begin
        if (blk == BLK_LAST) st_n = SQ_IDLE;
        else                 blk_n = blk + 1'b1;
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_IDLE;
      gap   <= '0;
      blk   <= '0;
      end_q <= 1'b0;
    end else begin
      st    <= st_n;
      gap   <= gap_n;
      blk   <= blk_n;
      end_q <= end_n;
    end
  end

  assign act_nxt = (st_n == SQ_ACTIVE);
  assign act_q   = (st == SQ_ACTIVE);
endmodule

// File: rtl/tx_squelch.sv
module tx_squelch #(
  parameter int MIN_PW    = 4,
  parameter int IDLE_TO   = 32,
  parameter int BLANK_LEN = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_lvl,
  input  logic tx_disable,
  output logic tx_enable,
  output logic tx_out,
  output logic tx_valid,
  output logic end_tx
);
  localparam int DLY_DEPTH = MIN_PW - 1;

  logic qual;
  logic act_nxt;
  logic dly_bit;

  tsq_width_filter #(.MIN_PW(MIN_PW)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .lvl  (tx_lvl),
    .qual (qual)
  );

  tsq_delay_line #(.DEPTH(DLY_DEPTH)) u_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (tx_lvl),
    .dout (dly_bit)
  );

  tsq_ctrl #(.IDLE_TO(IDLE_TO), .BLANK_LEN(BLANK_LEN)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .qual    (qual),
    .act_nxt (act_nxt),
    .act_q   (tx_valid),
    .end_q   (end_tx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_enable <= 1'b0;
      tx_out    <= 1'b0;
    end else begin
      tx_enable <= act_nxt & ~tx_disable;
      tx_out    <= act_nxt & ~tx_disable & dly_bit;
    end
  end
endmodule

// File: rtl/tx_squelch_chk.sv
module tx_squelch_chk (
  input logic clk,
  input logic rst,
  input logic tx_disable,
  input logic tx_enable,
  input logic tx_out,
  input logic tx_valid,
  input logic end_tx
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !tx_valid && !tx_enable && !tx_out && !end_tx);

  // R5
  end_on_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(tx_valid) |-> end_tx);

  // R5
  end_single_chk: assert property (@(posedge clk) disable iff (rst) end_tx |-> !tx_valid && $past(tx_valid));

  // R6
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst) end_tx |=> !tx_valid);

  // R8
  enable_needs_valid_chk: assert property (@(posedge clk) disable iff (rst) tx_enable |-> tx_valid);

  // R8
  disable_kills_chk: assert property (@(posedge clk) disable iff (rst) tx_disable |=> !tx_enable && !tx_out);

  // R7
  out_needs_enable_chk: assert property (@(posedge clk) disable iff (rst) tx_out |-> tx_enable);
endmodule

bind tx_squelch tx_squelch_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_disable (tx_disable),
  .tx_enable  (tx_enable),
  .tx_out     (tx_out),
  .tx_valid   (tx_valid),
  .end_tx     (end_tx)
);

// File: tb/tb_tx_squelch.sv
`timescale 1ns/1ps
module tb_tx_squelch;
  localparam int MIN_PW    = 4;
  localparam int IDLE_TO   = 32;
  localparam int BLANK_LEN = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_lvl = 1'b0;
  logic tx_disable = 1'b0;
  logic tx_enable, tx_out, tx_valid, end_tx;

  always #10 clk = ~clk;

  tx_squelch #(.MIN_PW(MIN_PW), .IDLE_TO(IDLE_TO), .BLANK_LEN(BLANK_LEN)) dut (
    .clk(clk), .rst(rst), .tx_lvl(tx_lvl), .tx_disable(tx_disable),
    .tx_enable(tx_enable), .tx_out(tx_out), .tx_valid(tx_valid), .end_tx(end_tx)
  );

  int n_vec = 0;
  int n_bad = 0;

  // reference state, driven from the requirements
  int  edge_no  = 0;
  int  run_len  = 0;
  bit  m_act    = 0;
  int  last_q   = 0;
  int  end_edge = -100000;
  bit  e_valid = 0, e_end = 0, e_en = 0, e_out = 0;
  bit  hist [64];
  string phase = "R1";

  task automatic chk(input string req, input string nm, input bit got, input bit exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s edge %0d phase %s: got %b expected %b", req, nm, edge_no, phase, got, exp);
    end
  endtask

  // one clock: compare results of previous edge, then apply inputs for next edge
  task automatic step(input bit lvl, input bit dis);
    int src;
    bit q;
    @(negedge clk);
    chk("R3 R4 R6", "tx_valid", tx_valid, e_valid);
    chk("R5", "end_tx", end_tx, e_end);
    chk("R8", "tx_enable", tx_enable, e_en);
    chk("R7", "tx_out", tx_out, e_out);
    tx_lvl = lvl;
    tx_disable = dis;
    edge_no++;
    hist[edge_no % 64] = lvl;
    run_len = lvl ? run_len + 1 : 0;
    q = (run_len == MIN_PW);
    e_end = 0;
    if (m_act) begin
      if (q) last_q = edge_no;
      else if (edge_no - last_q == IDLE_TO) begin
        m_act = 0; e_end = 1; end_edge = edge_no;
      end
    end else if (q && edge_no > end_edge + BLANK_LEN) begin
      m_act = 1; last_q = edge_no;
    end
    src = edge_no - MIN_PW + 1;
    e_valid = m_act;
    e_en = m_act && !dis;
    e_out = m_act && !dis && (src > 0) && hist[src % 64];
  endtask

  task automatic pulse(input int w, input int g, input bit dis);
    for (int i = 0; i < w; i++) step(1'b1, dis);
    for (int i = 0; i < g; i++) step(1'b0, dis);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 64; i++) hist[i] = 0;
    // R1: reset state
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "tx_valid", tx_valid, 1'b0);
    chk("R1", "tx_enable", tx_enable, 1'b0);
    chk("R1", "tx_out", tx_out, 1'b0);
    chk("R1", "end_tx", end_tx, 1'b0);
    rst = 1'b0;

    // R2: sub-width pulses, many gap lengths
    phase = "R2";
    for (int w = 1; w < MIN_PW; w++)
      for (int g = 1; g < 12; g++)
        for (int k = 0; k < 5; k++) pulse(w, g, 1'b0);
    pulse(0, 20, 1'b0);
    chk("R2", "tx_valid after short pulses", tx_valid, 1'b0);

    // R3 R4 R7: width x gap sweep across the timeout boundary
    phase = "R4";
    for (int w = 1; w <= 8; w++)
      for (int g = 1; g <= 44; g += (g < 28 || g > 36) ? 3 : 1) begin
        for (int k = 0; k < 4; k++) pulse(w, g, 1'b0);
        pulse(0, IDLE_TO + BLANK_LEN + 10, 1'b0);
      end

    // R6: second pulse swept across the blanking window edge
    phase = "R6";
    for (int d = 0; d <= 60; d++) begin
      pulse(MIN_PW + 1, IDLE_TO + d, 1'b0);
      pulse(MIN_PW + 2, IDLE_TO + BLANK_LEN + 10, 1'b0);
    end

    // R8: disable held across a whole transmission
    phase = "R8";
    pulse(6, 3, 1'b1);
    pulse(6, IDLE_TO + BLANK_LEN + 10, 1'b1);

    // R7 R8: pseudo-random level and disable
    phase = "R7";
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], (lfsr[7:3] == 5'd0));
    end
    pulse(0, IDLE_TO + BLANK_LEN + 4, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule